// File: doc/BRIEF.md
# Software System Reset Control Port

This block is a one-byte I/O register that lets software ask for a system-wide reset. The register sits at the fixed I/O address 0xCF9. A write whose command bit (bit 2) is set does not change the register. It produces a one-clock reset request pulse that a separate reset sequencer acts on. Any other write to the port keeps only the reset-type bit (bit 1) and clears every other bit.

The block is a leaf on an I/O decode path. It receives an address, read and write strobes and write data, and it returns read data. Software reads back the stored reset type. A read or write at any other address has no effect, and the read data is zero.

Top module: `rstctl_port`

## Requirements
- R1: After reset the stored value is 0x00 and the reset request output is low.
- R2: The port decodes only when all 16 address bits equal 0xCF9. A write at any other address, including addresses that match only in the low 12 bits, leaves the stored value unchanged.
- R3: The read data is 0x00 whenever the read strobe is low or the address is not 0xCF9.
- R4: A decoded write with bit 2 set drives the reset request high for exactly the clock cycle that follows the write edge. The stored value is not changed by that write.
- R5: A decoded write with bit 2 clear stores bit 1 of the write data into bit 1 of the register and stores zero into every other bit.
- R6: A decoded read returns the stored value in the same cycle as the read strobe.
- R7: The reset request is high only in a cycle whose previous edge saw a decoded write with bit 2 set. Back-to-back such writes give one high cycle per write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; zero unless there is a decoded read |
| sys_rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The assertions check on every cycle four properties:
- a request pulse is always preceded by a decoded reset command;
- a reset command or a write at another address never alters the stored value;
- a plain write stores only the type bit;
- the read data stays zero outside a decoded read.

Only the bench scenarios can show the rest. These are the exact values read back after sequences of writes, back-to-back request pulses, near-miss addresses and a mid-run reset. The bench checks each of them against a behavioural model on every clock.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int DATA_W      = 8;
  localparam int CMD_BIT     = 2;  // write-only reset command
  localparam int TYPE_BIT    = 1;  // retained reset type

  function automatic logic is_reset_cmd(input logic [DATA_W-1:0] d);
    return d[CMD_BIT];
  endfunction

  function automatic logic [DATA_W-1:0] keep_type(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] m;
    m = '0;
    m[TYPE_BIT] = 1'b1;
    return d & m;
  endfunction
endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode #(
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              hit_wr,
  output logic              hit_rd
);
  logic match;
  assign match  = (addr == PORT_ADDR);
  assign hit_wr = match & wr;
  assign hit_rd = match & rd;
endmodule

// File: rtl/rstctl_store.sv
module rstctl_store
  import rstctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stored,
  output logic              req
);
  logic cmd_reset;
  logic cmd_store;

  assign cmd_reset = hit_wr & is_reset_cmd(wdata);
  assign cmd_store = hit_wr & ~is_reset_cmd(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored <= '0;
      req    <= 1'b0;
    end else begin
      req <= cmd_reset;
      if (cmd_store) stored <= keep_type(wdata);
    end
  end

  AST_REQ_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(hit_wr) && $past(wdata[CMD_BIT])); // R7

  AST_CMD_HOLDS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> $stable(stored)); // R4

  AST_STORE_TYPE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_store |=> stored == {{(DATA_W-TYPE_BIT-1){1'b0}}, $past(wdata[TYPE_BIT]), {TYPE_BIT{1'b0}}}); // R5
endmodule

// File: rtl/rstctl_port.sv
module rstctl_port
  import rstctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              sys_rst_req
);
  logic              hit_wr;
  logic              hit_rd;
  logic [DATA_W-1:0] stored;

  rstctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(io_addr), .wr(io_wr), .rd(io_rd), .hit_wr(hit_wr), .hit_rd(hit_rd)
  );

  rstctl_store u_store (
    .clk(clk), .rst_n(rst_n), .hit_wr(hit_wr), .wdata(io_wdata),
    .stored(stored), .req(sys_rst_req)
  );

  assign io_rdata = hit_rd ? stored : '0;

  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != PORT_ADDR) |=> $stable(stored)); // R2

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd || io_addr != PORT_ADDR) |-> io_rdata == '0); // R3
endmodule

// File: tb/test_rstctl_port.sv
module test_rstctl_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        sys_rst_req;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_reg  = 0;
  int exp_req  = 0;

  always #10 clk = ~clk;

  rstctl_port i_rstctl_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .sys_rst_req(sys_rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check rdata, then the request after the edge
  task automatic step(input int addr, input bit wr, input bit rd, input int d);
    bit hit;
    io_addr = addr[15:0]; io_wr = wr; io_rd = rd; io_wdata = d[7:0];
    hit = (addr == 'hCF9);
    #2;
    check((hit && rd) ? "R6 read value" : "R3 quiet read", int'(io_rdata),
          (hit && rd) ? exp_reg : 0);
    @(posedge clk);
    exp_req = (hit && wr && d[2]) ? 1 : 0;          // R4 R7
    if (hit && wr && !d[2]) exp_reg = d & 'h02;      // R5
    @(negedge clk);
    check("R4 request pulse", int'(sys_rst_req), exp_req);
  endtask

  task automatic rd_port(input int exp, input string req);
    step('hCF9, 0, 1, 0);
    check(req, exp_reg, exp);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 request low in reset", int'(sys_rst_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_port(0, "R1 reset value");
    step('hCF9, 1, 0, 'hFF);                         // R4 command, no store
    rd_port(0, "R4 value kept");
    step('hCF9, 1, 0, 'h02);                         // R5
    rd_port(2, "R5 type stored");
    step('hCF9, 1, 0, 'hFB);                         // R5 mask
    rd_port(2, "R5 masked");
    step('hCF9, 1, 0, 'h01);
    rd_port(0, "R5 clear");
    step('hCF9, 1, 0, 'h0A);
    step('hCF9, 1, 0, 'h06);                         // R4 keep 2
    rd_port(2, "R4 value kept after command");
    step('hCF9, 1, 0, 'h04);                         // R7 back to back
    step('hCF9, 1, 0, 'h04);
    step('hCF9, 0, 0, 'h04);
    step('hCF8, 1, 0, 'h00);                         // R2 foreign writes
    step('h1CF9, 1, 0, 'h00);
    step('hCFA, 1, 0, 'h04);
    rd_port(2, "R2 foreign write ignored");
    step('hCF8, 0, 1, 0);                            // R3
    step('hDCF9, 0, 1, 0);
    step('hCF9, 0, 0, 0);
    step('hCF9, 1, 1, 'h00);                         // R6 read during write
    rd_port(0, "R6 after write");
    step('hCF9, 1, 0, 'h02);
    rst_n = 1'b0; exp_reg = 0; exp_req = 0;
    #2;
    check("R1 request low in reset", int'(sys_rst_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_port(0, "R1 value after reset");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule